// File: doc/BRIEF.md
# Staged Chip Timing and Mode Register Updater

This block is a register file on an APB slave port. It serves up to four external memory chip selects. Software first writes a new timing word and a new mode word into two shared staging registers. Those writes change nothing that the memory interface uses. The live per-chip registers change only when software writes a direct command that names a chip and asks for an update. At that clock edge both staged values move into the named chip's live registers together. This lets software retime a chip while code is still being fetched from that same chip.

A direct command can also ask for a memory-side operation. In that case the block raises a single-cycle request pulse that carries the command kind and the chip number, and the memory sequencer acts on it. A state input from the power controller blocks writes to the staged mode word whenever the controller is not in its ready state. Each chip's live registers can be read back. Chips beyond the fitted count read as zero.

Top module: `chipcfg_updater`

## Requirements
- R1: After reset every staged and live register is zero and `cmd_req` is low. A read of a fitted chip's live mode word then returns only that chip's match byte in bits [31:24].
- R2: Writes to the staged timing word (offset 0x014) and the staged mode word (offset 0x018) leave every chip's live registers unchanged until a direct command arrives.
- R3: A write to offset 0x010 has the chip number in bits [1:0] and the command kind in bits [5:4]. With kind 00 (update) or 10 (update and issue), it copies both staged words into that chip's live registers at the same edge. No other chip changes.
- R4: Kind 01 (issue) or 10 raises `cmd_req` for exactly one cycle, starting at the edge that accepts the write. During that cycle `cmd_type` holds the kind and `cmd_chip` holds the chip number. Kind 00 raises no request. Kind 11 is ignored entirely.
- R5: A direct command naming a chip number of NCHIP or above updates nothing and raises no request.
- R6: Writes to the staged mode word are dropped while `ctl_state` is 01 (low power) or 10 (reset), and also while it is 11. They are taken only when it is 00. Writes to the staged timing word are taken in every state.
- R7: Bits [31:16] of a staged mode write are dropped. A live mode word reads back as {match byte of the chip, 8'h00, mode[15:0]}.
- R8: `chip_wr_bl` gives, for each chip n in slice [3n+2:3n], bits [9:7] of that chip's live mode word.
- R9: Chip n's live timing word reads at 0x100+0x20·n and its live mode word at 0x104+0x20·n. Both read as zero when n is not fitted.
- R10: Reads of the write-only offsets 0x010, 0x014 and 0x018, and reads of any unmapped offset, return zero. Writes to the live-register offsets have no effect.
- R11: The staged timing word keeps bits [CYC_W-1:0] of a write and drops the rest. The live timing word reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_state | input | 2 | Controller state: 00 ready, 01 low power, 10 reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 12 | APB byte offset |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| cmd_req | output | 1 | One-cycle memory command request |
| cmd_type | output | 2 | Kind of the requested command |
| cmd_chip | output | 2 | Chip targeted by the request |
| chip_cycles | output | NCHIP·CYC_W | Live timing words, chip n at slice n |
| chip_opmode | output | NCHIP·16 | Live mode words, chip n at slice n |
| chip_wr_bl | output | NCHIP·3 | Write burst length field of each live mode word |

## Verification
Suppose a staged word leaks into the live set before a command. Then the live-register read-back and `chip_wr_bl` change within one clock of the staging write, with no command in between. A wrong chip decode shows up as a neighbour's live words changing on the command edge. A broken power-state gate shows up later, at the next update command, when a mode value written during low power or reset appears in the live word. A broken request path shows up as a missing, stretched or mislabelled `cmd_req` on the cycle right after the command write.

// File: rtl/chipcfg_pkg.sv
package chipcfg_pkg;

   localparam int MAX_CHIPS = 4;
   localparam int OPM_W     = 16;
   localparam int BL_LSB    = 7;
   localparam int BL_W      = 3;

   localparam logic [11:0] OFS_CMD   = 12'h010;
   localparam logic [11:0] OFS_CYC   = 12'h014;
   localparam logic [11:0] OFS_OPM   = 12'h018;
   localparam logic [11:0] OFS_CHIP0 = 12'h100;
   localparam logic [11:0] CHIP_STEP = 12'h020;
   localparam logic [11:0] OPM_SUB   = 12'h004;

   typedef enum logic [1:0] {
      CMD_UPDATE = 2'b00,
      CMD_ISSUE  = 2'b01,
      CMD_BOTH   = 2'b10,
      CMD_RSVD   = 2'b11
   } cmd_kind_e;

   typedef enum logic [1:0] {
      ST_READY  = 2'b00,
      ST_LOWPWR = 2'b01,
      ST_RESET  = 2'b10,
      ST_SPARE  = 2'b11
   } ctl_state_e;

   function automatic logic [11:0] chip_base(input int n);
      return OFS_CHIP0 + CHIP_STEP * 12'(n);
   endfunction

endpackage

// File: rtl/chipcfg_apb_decode.sv
module chipcfg_apb_decode
   import chipcfg_pkg::*;
(
   input  logic        psel,
   input  logic        penable,
   input  logic        pwrite,
   input  logic [11:0] paddr,
   output logic        wr_cmd,
   output logic        wr_cyc,
   output logic        wr_opm,
   output logic        rd_en
);
   logic wr_acc;

   assign wr_acc = psel && penable && pwrite;
   assign wr_cmd = wr_acc && (paddr == OFS_CMD);
   assign wr_cyc = wr_acc && (paddr == OFS_CYC);
   assign wr_opm = wr_acc && (paddr == OFS_OPM);
   assign rd_en  = psel && !pwrite;

endmodule

// File: rtl/chipcfg_holding.sv
module chipcfg_holding
   import chipcfg_pkg::*;
#(
   parameter int CYC_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cyc,
   input  logic             wr_opm,
   input  logic [1:0]       ctl_state,
   input  logic [31:0]      wdata,
   output logic [CYC_W-1:0] hold_cyc,
   output logic [OPM_W-1:0] hold_opm
);
   logic opm_open;

   assign opm_open = (ctl_state_e'(ctl_state) == ST_READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cyc <= '0;
      end else if (wr_cyc) begin
         hold_cyc <= wdata[CYC_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_opm <= '0;
      end else if (wr_opm && opm_open) begin
         hold_opm <= wdata[OPM_W-1:0];
      end
   end

endmodule

// File: rtl/chipcfg_cmd_ctl.sv
module chipcfg_cmd_ctl
   import chipcfg_pkg::*;
#(
   parameter int NCHIP = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_cmd,
   input  logic [31:0]      wdata,
   output logic [NCHIP-1:0] upd_vec,
   output logic             cmd_req,
   output logic [1:0]       cmd_type,
   output logic [1:0]       cmd_chip
);
   logic [1:0] sel;
   cmd_kind_e  kind;
   logic       fitted;
   logic       do_upd;
   logic       do_req;

   assign sel    = wdata[1:0];
   assign kind   = cmd_kind_e'(wdata[5:4]);
   assign fitted = (32'(sel) < NCHIP);
   assign do_upd = wr_cmd && fitted && (kind == CMD_UPDATE || kind == CMD_BOTH);
   assign do_req = wr_cmd && fitted && (kind == CMD_ISSUE || kind == CMD_BOTH);

   for (genvar n = 0; n < NCHIP; n++) begin : g_sel
      assign upd_vec[n] = do_upd && (sel == 2'(n));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_req  <= 1'b0;
         cmd_type <= 2'b00;
         cmd_chip <= 2'b00;
      end else begin
         cmd_req <= do_req;
         if (do_req) begin
            cmd_type <= wdata[5:4];
            cmd_chip <= sel;
         end
      end
   end

endmodule

// File: rtl/chipcfg_chip_slot.sv
module chipcfg_chip_slot
   import chipcfg_pkg::*;
#(
   parameter int CYC_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  logic [CYC_W-1:0] hold_cyc,
   input  logic [OPM_W-1:0] hold_opm,
   output logic [CYC_W-1:0] live_cyc,
   output logic [OPM_W-1:0] live_opm
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_cyc <= '0;
         live_opm <= '0;
      end else if (upd) begin
         live_cyc <= hold_cyc;
         live_opm <= hold_opm;
      end
   end

endmodule

// File: rtl/chipcfg_updater.sv
module chipcfg_updater
   import chipcfg_pkg::*;
#(
   parameter int          NCHIP      = 3,
   parameter int          CYC_W      = 20,
   parameter logic [31:0] ADDR_MATCH = 32'h4030_2010
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [1:0]             ctl_state,
   input  logic                   psel,
   input  logic                   penable,
   input  logic                   pwrite,
   input  logic [11:0]            paddr,
   input  logic [31:0]            pwdata,
   output logic [31:0]            prdata,
   output logic                   cmd_req,
   output logic [1:0]             cmd_type,
   output logic [1:0]             cmd_chip,
   output logic [NCHIP*CYC_W-1:0] chip_cycles,
   output logic [NCHIP*OPM_W-1:0] chip_opmode,
   output logic [NCHIP*BL_W-1:0]  chip_wr_bl
);
   localparam int PAD_W = 32 - CYC_W;

   initial begin
      assert (NCHIP >= 1 && NCHIP <= MAX_CHIPS)
         else $error("chipcfg_updater: NCHIP out of range");
      assert (CYC_W >= 1 && CYC_W <= 32)
         else $error("chipcfg_updater: CYC_W out of range");
   end

   logic             wr_cmd, wr_cyc, wr_opm, rd_en;
   logic [CYC_W-1:0] hold_cyc;
   logic [OPM_W-1:0] hold_opm;
   logic [NCHIP-1:0] upd_vec;
   logic [31:0]      rd_word [NCHIP*2];

   chipcfg_apb_decode u_dec (
      .psel    (psel),
      .penable (penable),
      .pwrite  (pwrite),
      .paddr   (paddr),
      .wr_cmd  (wr_cmd),
      .wr_cyc  (wr_cyc),
      .wr_opm  (wr_opm),
      .rd_en   (rd_en)
   );

   chipcfg_holding #(.CYC_W(CYC_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_cyc    (wr_cyc),
      .wr_opm    (wr_opm),
      .ctl_state (ctl_state),
      .wdata     (pwdata),
      .hold_cyc  (hold_cyc),
      .hold_opm  (hold_opm)
   );

   chipcfg_cmd_ctl #(.NCHIP(NCHIP)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd   (wr_cmd),
      .wdata    (pwdata),
      .upd_vec  (upd_vec),
      .cmd_req  (cmd_req),
      .cmd_type (cmd_type),
      .cmd_chip (cmd_chip)
   );

   for (genvar n = 0; n < NCHIP; n++) begin : g_chip
      logic [CYC_W-1:0] live_cyc;
      logic [OPM_W-1:0] live_opm;

      chipcfg_chip_slot #(.CYC_W(CYC_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .upd      (upd_vec[n]),
         .hold_cyc (hold_cyc),
         .hold_opm (hold_opm),
         .live_cyc (live_cyc),
         .live_opm (live_opm)
      );

      assign chip_cycles[n*CYC_W +: CYC_W] = live_cyc;
      assign chip_opmode[n*OPM_W +: OPM_W] = live_opm;
      assign chip_wr_bl[n*BL_W +: BL_W]    = live_opm[BL_LSB +: BL_W];

      if (PAD_W > 0) begin : g_pad
         assign rd_word[2*n] = {{PAD_W{1'b0}}, live_cyc};
      end else begin : g_nopad
         assign rd_word[2*n] = 32'(live_cyc);
      end
      assign rd_word[2*n+1] = {ADDR_MATCH[8*n +: 8], 8'h00, live_opm};
   end

   always_comb begin
      prdata = '0;
      if (rd_en) begin
         for (int n = 0; n < NCHIP; n++) begin
            if (paddr == chip_base(n))           prdata = rd_word[2*n];
            if (paddr == chip_base(n) + OPM_SUB) prdata = rd_word[2*n+1];
         end
      end
   end

endmodule

// File: rtl/chipcfg_updater_chk.sv
module chipcfg_updater_chk
   import chipcfg_pkg::*;
#(
   parameter int          NCHIP      = 3,
   parameter int          CYC_W      = 20,
   parameter logic [31:0] ADDR_MATCH = 32'h4030_2010
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   psel,
   input logic                   penable,
   input logic                   pwrite,
   input logic [11:0]            paddr,
   input logic [31:0]            prdata,
   input logic                   cmd_req,
   input logic [1:0]             cmd_chip,
   input logic [NCHIP*CYC_W-1:0] chip_cycles,
   input logic [NCHIP*OPM_W-1:0] chip_opmode
);
   logic cmd_wr;
   logic rd_wo;

   assign cmd_wr = psel && penable && pwrite && (paddr == 12'h010);
   assign rd_wo  = psel && !pwrite &&
                   (paddr == 12'h010 || paddr == 12'h014 || paddr == 12'h018);

   // R4
   cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |=> !cmd_req);

   // R4
   cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> $past(cmd_wr));

   // R5
   cmd_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_req |-> (32'(cmd_chip) < NCHIP));

   // R2
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cmd_wr) |-> ($stable(chip_cycles) && $stable(chip_opmode)));

   // R10
   wo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_wo |-> (prdata == 32'h0));

   // R7
   match_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psel && !pwrite && paddr == 12'h104) |-> (prdata[31:16] == {ADDR_MATCH[7:0], 8'h00}));

endmodule

bind chipcfg_updater chipcfg_updater_chk #(
   .NCHIP(NCHIP), .CYC_W(CYC_W), .ADDR_MATCH(ADDR_MATCH)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .psel        (psel),
   .penable     (penable),
   .pwrite      (pwrite),
   .paddr       (paddr),
   .prdata      (prdata),
   .cmd_req     (cmd_req),
   .cmd_chip    (cmd_chip),
   .chip_cycles (chip_cycles),
   .chip_opmode (chip_opmode)
);

// File: tb/chipcfg_updater_tb_top.sv
module chipcfg_updater_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCHIP      = 3;
   localparam int CYC_W      = 20;

   logic                   clk = 1'b0;
   logic                   rst_n = 1'b0;
   logic [1:0]             ctl_state = 2'b00;
   logic                   psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0]            paddr = '0;
   logic [31:0]            pwdata = '0;
   logic [31:0]            prdata;
   logic                   cmd_req;
   logic [1:0]             cmd_type, cmd_chip;
   logic [NCHIP*CYC_W-1:0] chip_cycles;
   logic [NCHIP*16-1:0]    chip_opmode;
   logic [NCHIP*3-1:0]     chip_wr_bl;

   int errors = 0;
   int checks = 0;
   bit done   = 0;

   typedef struct {
      logic [31:0] exp;
      string       tag;
   } rd_item_t;

   rd_item_t   rdq[$];
   logic [3:0] reqq[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   chipcfg_updater #(.NCHIP(NCHIP), .CYC_W(CYC_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .ctl_state(ctl_state),
      .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .cmd_req(cmd_req), .cmd_type(cmd_type), .cmd_chip(cmd_chip),
      .chip_cycles(chip_cycles), .chip_opmode(chip_opmode), .chip_wr_bl(chip_wr_bl)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(posedge clk); #1;
      psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
      @(posedge clk); #1;
      penable = 1'b1;
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      rd_item_t it;
      it.exp = exp;
      it.tag = tag;
      rdq.push_back(it);
      @(posedge clk); #1;
      psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
      @(posedge clk); #1;
      penable = 1'b1;
      @(posedge clk); #1;
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic send_cmd(input int chip, input logic [1:0] kind);
      if (chip < NCHIP && (kind == 2'b01 || kind == 2'b10))
         reqq.push_back({kind, 2'(chip)});
      apb_wr(12'h010, {26'h0, kind, 2'b00, 2'(chip)});
   endtask

   // read monitor: scoreboard pops one expected item per completed read
   always @(negedge clk) begin
      if (rst_n && psel && penable && !pwrite) begin
         if (rdq.size() == 0) begin
            checks++; errors++;
            $display("FAIL read with empty scoreboard: got %h expected none", prdata);
         end else begin
            rd_item_t it;
            it = rdq.pop_front();
            chk(it.tag, prdata, it.exp);
         end
      end
   end

   // request monitor (R4, R5)
   always @(negedge clk) begin
      if (rst_n && cmd_req) begin
         if (reqq.size() == 0) begin
            checks++; errors++;
            $display("FAIL R4/R5 unexpected request: got %h expected none", {cmd_type, cmd_chip});
         end else begin
            logic [3:0] e;
            e = reqq.pop_front();
            chk("R4 request kind/chip", 32'({cmd_type, cmd_chip}), 32'(e));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 cmd_req after reset", 32'(cmd_req), 32'h0);
      chk("R1 wr_bl after reset", 32'(chip_wr_bl), 32'h0);
      apb_rd(12'h104, 32'h1000_0000, "R1 chip0 mode reset");
      apb_rd(12'h100, 32'h0, "R1 chip0 timing reset");

      // R11 / R7 staging, R2 no effect on live
      apb_wr(12'h014, 32'hFFF1_2345);
      apb_wr(12'h018, 32'hABCD_0380);
      apb_rd(12'h100, 32'h0, "R2 live timing unchanged after staging");
      apb_rd(12'h124, 32'h2000_0000, "R2 live mode unchanged after staging");
      chk("R2 wr_bl unchanged after staging", 32'(chip_wr_bl), 32'h0);
      apb_rd(12'h014, 32'h0, "R10 write-only timing reads zero");
      apb_rd(12'h018, 32'h0, "R10 write-only mode reads zero");

      // R3 update chip1
      send_cmd(1, 2'b00);
      chk("R8 chip1 wr_bl", 32'(chip_wr_bl[5:3]), 32'h7);
      chk("R3 chip0 wr_bl untouched", 32'(chip_wr_bl[2:0]), 32'h0);
      apb_rd(12'h120, 32'h0001_2345, "R11 chip1 timing truncated");
      apb_rd(12'h124, 32'h2000_0380, "R7 chip1 mode upper dropped");
      apb_rd(12'h104, 32'h1000_0000, "R3 chip0 untouched");

      // R4 issue only, chip2
      send_cmd(2, 2'b01);
      apb_rd(12'h140, 32'h0, "R4 issue-only leaves chip2");

      // R3/R4 both, chip0
      send_cmd(0, 2'b10);
      apb_rd(12'h100, 32'h0001_2345, "R3 chip0 timing updated");
      apb_rd(12'h104, 32'h1000_0380, "R3 chip0 mode updated");

      // R4 reserved kind ignored
      send_cmd(2, 2'b11);
      apb_rd(12'h144, 32'h3000_0000, "R4 reserved kind ignored");

      // R5 unfitted chip
      send_cmd(3, 2'b10);
      apb_rd(12'h160, 32'h0, "R9 unfitted chip timing zero");
      apb_rd(12'h164, 32'h0, "R9 unfitted chip mode zero");

      // R6 low power blocks mode staging, timing still taken
      ctl_state = 2'b01;
      apb_wr(12'h018, 32'h0000_0100);
      apb_wr(12'h014, 32'h0000_0055);
      ctl_state = 2'b00;
      send_cmd(2, 2'b00);
      apb_rd(12'h140, 32'h0000_0055, "R6 timing taken in low power");
      apb_rd(12'h144, 32'h3000_0380, "R6 mode write dropped in low power");

      // R6 reset state blocks mode staging
      ctl_state = 2'b10;
      apb_wr(12'h018, 32'h0000_0080);
      ctl_state = 2'b00;
      send_cmd(2, 2'b00);
      apb_rd(12'h144, 32'h3000_0380, "R6 mode write dropped in reset state");

      // R6 ready accepts
      apb_wr(12'h018, 32'h0000_0080);
      send_cmd(2, 2'b00);
      apb_rd(12'h144, 32'h3000_0080, "R6 mode write taken in ready");
      chk("R8 chip2 wr_bl", 32'(chip_wr_bl[8:6]), 32'h1);

      // R10 writes to live registers ignored, unmapped reads zero
      apb_wr(12'h124, 32'hFFFF_FFFF);
      apb_wr(12'h120, 32'hFFFF_FFFF);
      apb_rd(12'h124, 32'h2000_0380, "R10 live mode write ignored");
      apb_rd(12'h120, 32'h0001_2345, "R10 live timing write ignored");
      apb_rd(12'h010, 32'h0, "R10 command reads zero");
      apb_rd(12'h0FC, 32'h0, "R10 unmapped reads zero");
      apb_rd(12'h200, 32'h0, "R10 unmapped high reads zero");

      repeat (3) @(posedge clk);
      chk("R5 all requests seen, none extra", 32'(reqq.size()), 32'h0);
      chk("R9 all reads completed", 32'(rdq.size()), 32'h0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule